// File: doc/BRIEF.md
# Prefix Remap and Low-Address Store Guard

This block sits right after address translation. It turns a real address into an absolute address. Each processor has an 8 KB prefix area, and the block exchanges the bottom 8 KB of real storage with that area. Real addresses in the bottom window are moved up by the prefix base. Real addresses inside the prefix area are moved down to the bottom window. Every other address is passed through unchanged.

The same cycle also decides whether a store is blocked by low-address protection. Two windows of the real address are guarded, each 512 bytes long: one at the start of storage and one at the start of the second 4 KB page. The guard is armed by a control enable bit. When translation is on, the guard is also waived if the space descriptor selected by the current address-space mode has its private bit set. Access-register mode is not supported. A store made in that mode while translation and the guard are both enabled raises a separate error flag, and no protection decision is made.

All results are registered. They appear one clock after the input is presented with its valid flag.

Top module: `prefix_remap_lap`

## Requirements
- R1: A real address below 0x2000 yields an absolute address equal to the real address plus the prefix base. This rule takes precedence over R2.
- R2: A real address that is at least the prefix base and less than prefix base + 0x2000, and is not covered by R1, yields the real address minus the prefix base.
- R3: Any other real address yields itself unchanged.
- R4: `out_valid` equals `in_valid` delayed by one clock. All outputs are zero while reset is asserted. The results for an input appear in the cycle after it is presented.
- R5: `prot_fault` and `mode_error` can only be raised by a store (`is_write`=1) presented while `lap_enable`=1. Reads and disabled stores never raise either flag.
- R6: The protected real-address ranges are 0..511 and 4096..4607, both inclusive. Addresses 512..4095 and addresses from 4608 upward are never protected.
- R7: With `xlat_enable`=0, a guarded store in a protected range faults whatever the mode and the private bits are. `mode_error` stays 0 in that case.
- R8: With `xlat_enable`=1, the private bit is selected by `space_mode`: 2'b00 selects primary, 2'b10 selects secondary and 2'b11 selects home. If the selected bit is set, protection is waived. If it is clear, protection applies. The private bits of the other modes have no effect.
- R9: With `xlat_enable`=1 and `space_mode`=2'b01 (access-register mode), a guarded store raises `mode_error` at any address and never raises `prot_fault`.
- R10: In a cycle that follows an idle input cycle (`in_valid`=0), both `prot_fault` and `mode_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The input request is valid |
| real_addr | input | AW | Real address after translation |
| is_write | input | 1 | The access is a store |
| prefix_base | input | AW | Per-processor prefix base, 8 KB aligned |
| lap_enable | input | 1 | Control enable for low-address protection |
| xlat_enable | input | 1 | Dynamic address translation is on |
| space_mode | input | 2 | Address-space mode: 00 primary, 01 access-register, 10 secondary, 11 home |
| priv_primary | input | 1 | Private bit of the primary space descriptor |
| priv_secondary | input | 1 | Private bit of the secondary space descriptor |
| priv_home | input | 1 | Private bit of the home space descriptor |
| out_valid | output | 1 | The result registers hold a valid result |
| abs_addr | output | AW | Absolute address |
| prot_fault | output | 1 | Store blocked by low-address protection (the exception word is all zero) |
| mode_error | output | 1 | Guarded store made in the unsupported access-register mode |

## Verification
The bench targets the edges of the guarded windows:
- 511 and 512 at the start of storage.
- 4095, 4096, 4607 and 4608 around the second window.

A design with an off-by-one comparison either lets one store through or blocks a legal one. The bench also drives the edges of both 8 KB windows: 0x1FFF, 0x2000, the prefix base itself and the prefix base + 0x1FFF. It includes a prefix of zero, where the two swap rules overlap and the bottom-window rule must take precedence. Random stimulus crosses all four modes with every combination of private bits. A design that reads the wrong descriptor's private bit, or that waives the guard with translation off, is then reported by the bench. Access-register stores also check that the error flag is raised in place of a protection fault.

// File: rtl/prefix_remap_lap_pkg.sv
package prefix_remap_lap_pkg;

  typedef enum logic [1:0] {
    SPACE_PRIMARY   = 2'b00,
    SPACE_ACCREG    = 2'b01,
    SPACE_SECONDARY = 2'b10,
    SPACE_HOME      = 2'b11
  } space_mode_e;

endpackage

// File: rtl/prefix_swap.sv
module prefix_swap #(
  parameter int AW  = 64,
  parameter int WIN = 8192
) (
  input  logic [AW-1:0] real_addr,
  input  logic [AW-1:0] prefix,
  output logic [AW-1:0] abs_addr
);
  localparam logic [AW:0] WIN_EXT = (AW+1)'(WIN);

  logic [AW:0] real_ext;
  logic [AW:0] pfx_top;
  logic        in_low;
  logic        in_pfx;

  assign real_ext = {1'b0, real_addr};
  assign pfx_top  = {1'b0, prefix} + WIN_EXT;
  assign in_low   = real_ext < WIN_EXT;
  assign in_pfx   = (real_addr >= prefix) && (real_ext < pfx_top);

  always_comb begin
    if (in_low) begin
      abs_addr = real_addr + prefix;
    end else if (in_pfx) begin
      abs_addr = real_addr - prefix;
    end else begin
      abs_addr = real_addr;
    end
  end
endmodule

// File: rtl/lowaddr_guard.sv
module lowaddr_guard
  import prefix_remap_lap_pkg::*;
#(
  parameter int AW   = 64,
  parameter int SPAN = 512,
  parameter int PAGE = 4096
) (
  input  logic [AW-1:0] addr,
  input  logic          is_write,
  input  logic          lap_en,
  input  logic          xlat_en,
  input  logic [1:0]    mode,
  input  logic          priv_pri,
  input  logic          priv_sec,
  input  logic          priv_home,
  output logic          hit,
  output logic          mode_err
);
  localparam logic [AW-1:0] SPAN_V  = AW'(SPAN);
  localparam logic [AW-1:0] PAGE_V  = AW'(PAGE);
  localparam logic [AW-1:0] PAGE_HI = AW'(PAGE + SPAN);

  logic in_range;
  logic priv_sel;
  logic mode_ok;
  logic armed;

  assign in_range = (addr < SPAN_V) || ((addr >= PAGE_V) && (addr < PAGE_HI));
  assign armed    = lap_en && is_write;

  always_comb begin
    priv_sel = 1'b0;
    mode_ok  = 1'b1;
    unique case (space_mode_e'(mode))
      SPACE_PRIMARY:   priv_sel = priv_pri;
      SPACE_SECONDARY: priv_sel = priv_sec;
      SPACE_HOME:      priv_sel = priv_home;
      default:         mode_ok  = 1'b0;
    endcase
  end

  assign mode_err = armed && xlat_en && !mode_ok;
  assign hit      = armed && in_range && (!xlat_en || (mode_ok && !priv_sel));
endmodule

// File: rtl/prefix_remap_lap.sv
module prefix_remap_lap #(
  parameter int AW   = 64,
  parameter int WIN  = 8192,
  parameter int SPAN = 512,
  parameter int PAGE = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] real_addr,
  input  logic          is_write,
  input  logic [AW-1:0] prefix_base,
  input  logic          lap_enable,
  input  logic          xlat_enable,
  input  logic [1:0]    space_mode,
  input  logic          priv_primary,
  input  logic          priv_secondary,
  input  logic          priv_home,
  output logic          out_valid,
  output logic [AW-1:0] abs_addr,
  output logic          prot_fault,
  output logic          mode_error
);
  logic [AW-1:0] abs_c;
  logic          hit_c;
  logic          err_c;

  logic          valid_d, valid_q;
  logic [AW-1:0] abs_d,   abs_q;
  logic          fault_d, fault_q;
  logic          err_d,   err_q;

  prefix_swap #(.AW(AW), .WIN(WIN)) u_swap (
    .real_addr (real_addr),
    .prefix    (prefix_base),
    .abs_addr  (abs_c)
  );

  lowaddr_guard #(.AW(AW), .SPAN(SPAN), .PAGE(PAGE)) u_guard (
    .addr      (real_addr),
    .is_write  (is_write),
    .lap_en    (lap_enable),
    .xlat_en   (xlat_enable),
    .mode      (space_mode),
    .priv_pri  (priv_primary),
    .priv_sec  (priv_secondary),
    .priv_home (priv_home),
    .hit       (hit_c),
    .mode_err  (err_c)
  );

  always_comb begin
    valid_d = in_valid;
    abs_d   = abs_q;
    fault_d = 1'b0;
    err_d   = 1'b0;
    if (in_valid) begin
      abs_d   = abs_c;
      fault_d = hit_c;
      err_d   = err_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      abs_q   <= '0;
      fault_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      abs_q   <= abs_d;
      fault_q <= fault_d;
      err_q   <= err_d;
    end
  end

  assign out_valid  = valid_q;
  assign abs_addr   = abs_q;
  assign prot_fault = fault_q;
  assign mode_error = err_q;
endmodule

// File: rtl/prefix_remap_lap_chk.sv
module prefix_remap_lap_chk #(
  parameter int AW  = 64,
  parameter int WIN = 8192
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [AW-1:0] real_addr,
  input logic          is_write,
  input logic [AW-1:0] prefix_base,
  input logic          lap_enable,
  input logic          out_valid,
  input logic [AW-1:0] abs_addr,
  input logic          prot_fault,
  input logic          mode_error
);
  localparam logic [AW-1:0] WIN_V = AW'(WIN);

  logic seen_clk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_clk <= 1'b0;
    else        seen_clk <= 1'b1;
  end

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen_clk |-> (out_valid == $past(in_valid)));

  p_low_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && real_addr < WIN_V) |=> (abs_addr == $past(real_addr + prefix_base)));

  p_read_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!is_write || !lap_enable)) |=> (!prot_fault && !mode_error));

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(prot_fault && mode_error));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!prot_fault && !mode_error));
endmodule

bind prefix_remap_lap prefix_remap_lap_chk #(.AW(AW), .WIN(WIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .real_addr   (real_addr),
  .is_write    (is_write),
  .prefix_base (prefix_base),
  .lap_enable  (lap_enable),
  .out_valid   (out_valid),
  .abs_addr    (abs_addr),
  .prot_fault  (prot_fault),
  .mode_error  (mode_error)
);

// File: tb/prefix_remap_lap_bench.sv
module prefix_remap_lap_bench;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [AW-1:0] real_addr;
  logic          is_write;
  logic [AW-1:0] prefix_base;
  logic          lap_enable;
  logic          xlat_enable;
  logic [1:0]    space_mode;
  logic          priv_primary;
  logic          priv_secondary;
  logic          priv_home;
  logic          out_valid;
  logic [AW-1:0] abs_addr;
  logic          prot_fault;
  logic          mode_error;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  prefix_remap_lap u_prefix_remap_lap (.*);

  function automatic logic [AW-1:0] ref_abs(logic [AW-1:0] a, logic [AW-1:0] p);
    if (a < 64'h2000) return a + p;
    if (a >= p && (a - p) < 64'h2000) return a - p;
    return a;
  endfunction

  function automatic bit ref_range(logic [AW-1:0] a);
    return (a <= 64'd511) || (a >= 64'd4096 && a <= 64'd4607);
  endfunction

  function automatic bit ref_err(bit w, bit le, bit xe, logic [1:0] m);
    return w && le && xe && (m == 2'b01);
  endfunction

  function automatic bit ref_fault(logic [AW-1:0] a, bit w, bit le, bit xe,
                                   logic [1:0] m, bit pp, bit ps, bit ph);
    bit priv;
    if (!(w && le) || !ref_range(a)) return 1'b0;
    if (!xe) return 1'b1;
    case (m)
      2'b00:   priv = pp;
      2'b10:   priv = ps;
      2'b11:   priv = ph;
      default: return 1'b0;
    endcase
    return !priv;
  endfunction

  task automatic check(bit ok, string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(logic [AW-1:0] a, bit w, logic [AW-1:0] p, bit le, bit xe,
                     logic [1:0] m, bit pp, bit ps, bit ph, string req);
    logic [AW-1:0] ea;
    bit ef, ee;
    in_valid = 1'b1; real_addr = a; is_write = w; prefix_base = p;
    lap_enable = le; xlat_enable = xe; space_mode = m;
    priv_primary = pp; priv_secondary = ps; priv_home = ph;
    ea = ref_abs(a, p);
    ef = ref_fault(a, w, le, xe, m, pp, ps, ph);
    ee = ref_err(w, le, xe, m);
    @(negedge clk);
    check(out_valid == 1'b1, "R4", "out_valid", out_valid, 1);
    check(abs_addr == ea, req, "abs_addr", abs_addr, ea);
    check(prot_fault == ef, req, "prot_fault", prot_fault, ef);
    check(mode_error == ee, req, "mode_error", mode_error, ee);
  endtask

  task automatic idle();
    in_valid = 1'b0; is_write = 1'b1; lap_enable = 1'b1; real_addr = '0;
    xlat_enable = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R4", "idle out_valid", out_valid, 0);
    check(!prot_fault && !mode_error, "R10", "idle flags", {prot_fault, mode_error}, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pfx;
    void'($urandom(32'd20240917));
    rst_n = 1'b0; in_valid = 1'b0; real_addr = '0; is_write = 1'b0;
    prefix_base = '0; lap_enable = 1'b0; xlat_enable = 1'b0; space_mode = 2'b00;
    priv_primary = 1'b0; priv_secondary = 1'b0; priv_home = 1'b0;
    @(negedge clk); @(negedge clk);
    check(!out_valid && abs_addr == '0 && !prot_fault && !mode_error, "R4", "reset outputs",
          abs_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    pfx = 64'h0000_0000_0012_4000;
    run(64'h0,    0, pfx, 0, 0, 2'b00, 0, 0, 0, "R1");
    run(64'h1FFF, 0, pfx, 0, 0, 2'b00, 0, 0, 0, "R1");
    run(64'h2000, 0, pfx, 0, 0, 2'b00, 0, 0, 0, "R3");
    run(pfx,      0, pfx, 0, 0, 2'b00, 0, 0, 0, "R2");
    run(pfx + 64'h1FFF, 0, pfx, 0, 0, 2'b00, 0, 0, 0, "R2");
    run(pfx + 64'h2000, 0, pfx, 0, 0, 2'b00, 0, 0, 0, "R3");
    run(pfx - 64'h1,    0, pfx, 0, 0, 2'b00, 0, 0, 0, "R3");
    run(64'h100,  0, 64'h0, 0, 0, 2'b00, 0, 0, 0, "R1");
    run(64'hFFFF_FFFF_FFFF_F000, 0, 64'hFFFF_FFFF_FFFF_E000, 0, 0, 2'b00, 0, 0, 0, "R2");

    run(64'd511,  1, pfx, 1, 0, 2'b01, 1, 1, 1, "R6");
    run(64'd512,  1, pfx, 1, 0, 2'b00, 0, 0, 0, "R6");
    run(64'd4095, 1, pfx, 1, 0, 2'b00, 0, 0, 0, "R6");
    run(64'd4096, 1, pfx, 1, 0, 2'b00, 0, 0, 0, "R6");
    run(64'd4607, 1, pfx, 1, 0, 2'b00, 0, 0, 0, "R6");
    run(64'd4608, 1, pfx, 1, 0, 2'b00, 0, 0, 0, "R6");
    run(64'd10,   0, pfx, 1, 0, 2'b00, 0, 0, 0, "R5");
    run(64'd10,   1, pfx, 0, 1, 2'b01, 0, 0, 0, "R5");
    run(64'd10,   1, pfx, 1, 0, 2'b01, 1, 1, 1, "R7");
    run(64'd10,   1, pfx, 1, 1, 2'b00, 1, 0, 0, "R8");
    run(64'd10,   1, pfx, 1, 1, 2'b00, 0, 1, 1, "R8");
    run(64'd10,   1, pfx, 1, 1, 2'b10, 0, 1, 0, "R8");
    run(64'd10,   1, pfx, 1, 1, 2'b10, 1, 0, 1, "R8");
    run(64'd10,   1, pfx, 1, 1, 2'b11, 0, 0, 1, "R8");
    run(64'd10,   1, pfx, 1, 1, 2'b11, 1, 1, 0, "R8");
    run(64'd10,   1, pfx, 1, 1, 2'b01, 0, 0, 0, "R9");
    run(64'h9000, 1, pfx, 1, 1, 2'b01, 0, 0, 0, "R9");
    run(64'd10,   0, pfx, 1, 1, 2'b01, 0, 0, 0, "R9");
    run(64'd10,   1, pfx, 1, 0, 2'b00, 0, 0, 0, "R10");
    idle();

    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      int sel;
      pfx = {$urandom() & 32'h0000_00FF, $urandom() & 32'hFFFF_E000};
      if ($urandom_range(0, 9) == 0) pfx = '0;
      sel = $urandom_range(0, 4);
      case (sel)
        0: a = 64'($urandom_range(0, 5000));
        1: a = 64'($urandom_range(0, 16'h3FFF));
        2: a = pfx + 64'($urandom_range(0, 16'h3FFF)) - 64'h1000;
        3: a = {$urandom(), $urandom()};
        default: a = 64'($urandom_range(4000, 4700));
      endcase
      run(a, 1'($urandom()), pfx, 1'($urandom()), 1'($urandom()), 2'($urandom()),
          1'($urandom()), 1'($urandom()), 1'($urandom()), "R3");
      if ($urandom_range(0, 15) == 0) idle();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule